// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block forms the low 32 bits of the product of two 32-bit operands. The multiplier operand is consumed one 8-bit digit per internal cycle, lowest digit first. The block stops as soon as every multiplier bit above the digits already consumed is a copy of the sign. The result is the same whether the operands are read as signed or as unsigned, so one unit serves both kinds of multiply instruction in a simple processor pipeline.

A request is a one-cycle `start` together with a `condPass` flag. When `condPass` is low, the multiply is treated as a failed-condition instruction: it costs one cycle, does no arithmetic and keeps the previous result. When it is high, the operands are captured in a setup cycle and followed by 1 to 4 internal cycles. `done` then pulses and `cycleCount` reports how many internal cycles were spent.

Top module: `earlyMul`

## Requirements
- R1: When `done` pulses after an accepted request, `result` equals (opA × opB) mod 2^32 for the operands captured with `start`. `result` changes at no other time.
- R2: If multiplier (opB) bits [31:8] are all zeros or all ones, exactly 1 internal cycle is used and `cycleCount` reads 1.
- R3: Otherwise, if opB bits [31:16] are all zeros or all ones, 2 internal cycles are used and `cycleCount` reads 2.
- R4: Otherwise, if opB bits [31:24] are all zeros or all ones, 3 internal cycles are used and `cycleCount` reads 3.
- R5: In all remaining cases 4 internal cycles are used and `cycleCount` reads 4. `cycleCount` never exceeds 4.
- R6: With `condPass` high, `done` is seen after clock edge number 1 + m, counting the edge that samples `start` as edge 1, where m is the internal-cycle count.
- R7: With `condPass` low, `done` is seen right after the edge that samples `start`, `cycleCount` reads 0 and `result` is unchanged.
- R8: `busy` is high from the edge that accepts a request until the edge that raises `done`, and it is low while `done` is high. `done` lasts one cycle per request.
- R9: A `start` seen while `busy` is high is ignored. The running multiply keeps its operands and its latency.
- R10: After reset, `busy`, `done`, `result` and `cycleCount` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| condPass | input | 1 | High: perform the multiply; low: one-cycle no-op |
| opA | input | 32 | Multiplicand |
| opB | input | 32 | Multiplier; its upper bits set the cycle count |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Low 32 bits of the last completed product |
| cycleCount | output | 3 | Internal cycles used by the last request (0 to 4) |

## Verification
The bench builds the block with its default 32-bit width and 8-bit digit. That yields four possible cycle counts, so every termination tier, including the full four-cycle case, can be reached from plain operand choices. Multipliers placed on each tier boundary, such as 0xFF against 0x100 and -256 against -257, show whether the sign correction on the final digit is right. Signed extremes and random operands are also checked against a modulo-2^32 product.

// File: rtl/earlyMulPkg.sv
package earlyMulPkg;

  // strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic load;      // capture operands, clear accumulator
    logic step;      // add one digit's partial product
    logic lastStep;  // this digit is the final one
  } mulStrobeT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mulStateT;

endpackage

// File: rtl/earlyMulTier.sv
// Finds how many digits of the multiplier must be consumed:
// the smallest k such that all bits from DIGIT*k upward are sign copies.
module earlyMulTier #(
  parameter int WIDTH = 32,
  parameter int DIGIT = 8,
  parameter int STEPS = WIDTH / DIGIT,
  parameter int CNT_W = $clog2(STEPS + 1)
) (
  input  logic [WIDTH-1:0] mplier,
  output logic [CNT_W-1:0] tier
);

  logic [STEPS-1:0] uniformAbove;

  genvar k;
  generate
    for (k = 0; k < STEPS; k++) begin : g_level
      if (k == 0) begin : g_none
        assign uniformAbove[k] = 1'b0;
      end else begin : g_cmp
        assign uniformAbove[k] = (&mplier[WIDTH-1:DIGIT*k]) |
                                 (~|mplier[WIDTH-1:DIGIT*k]);
      end
    end
  endgenerate

  always_comb begin
    tier = CNT_W'(STEPS);
    for (int lvl = STEPS - 1; lvl >= 0; lvl--) begin
      if (uniformAbove[lvl]) tier = CNT_W'(lvl);
    end
  end

endmodule

// File: rtl/earlyMulCtrl.sv
module earlyMulCtrl
  import earlyMulPkg::*;
#(
  parameter int STEPS = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             condPass,
  input  logic [CNT_W-1:0] tierIn,
  output mulStrobeT        strobe,
  output logic [IDX_W-1:0] stepIdx,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cycleCount
);

  mulStateT         state;
  logic [CNT_W-1:0] tierReg;
  logic             acceptNow;
  logic             skipNow;
  logic             finalNow;

  always_comb begin
    acceptNow       = (state == ST_IDLE) && start && condPass;
    skipNow         = (state == ST_IDLE) && start && !condPass;
    finalNow        = (state == ST_RUN) &&
                      ((CNT_W'(stepIdx) + CNT_W'(1)) == tierReg);
    strobe.load     = acceptNow;
    strobe.step     = (state == ST_RUN);
    strobe.lastStep = finalNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      stepIdx    <= '0;
      tierReg    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      cycleCount <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (acceptNow) begin
            state   <= ST_RUN;
            stepIdx <= '0;
            tierReg <= tierIn;
            busy    <= 1'b1;
          end else if (skipNow) begin
            done       <= 1'b1;
            cycleCount <= '0;
          end
        end
        ST_RUN: begin
          if (finalNow) begin
            state      <= ST_IDLE;
            busy       <= 1'b0;
            done       <= 1'b1;
            cycleCount <= tierReg;
          end else begin
            stepIdx <= stepIdx + IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/earlyMulPath.sv
// Accumulates multiplicand x digit, one digit per step. The final digit
// is read as signed (borrowing the next multiplier bit as its sign), which
// accounts for the skipped sign-copy digits modulo 2^WIDTH.
module earlyMulPath
  import earlyMulPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DIGIT = 8,
  parameter int STEPS = WIDTH / DIGIT,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobeT        strobe,
  input  logic [IDX_W-1:0] stepIdx,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result
);

  localparam int DV_W = DIGIT + 2;

  logic [WIDTH-1:0] mcand;
  logic [WIDTH-1:0] mplier;
  logic [WIDTH-1:0] acc;
  logic [DIGIT-1:0] digit;
  logic             nextBit;
  logic             topDigit;
  logic             negDigit;
  logic [DV_W-1:0]  digitVal;
  logic [WIDTH-1:0] digitExt;
  logic [WIDTH-1:0] partial;
  logic [WIDTH-1:0] accNext;

  always_comb begin
    digit    = DIGIT'(mplier >> (DIGIT * int'(stepIdx)));
    nextBit  = |((mplier >> (DIGIT * int'(stepIdx) + DIGIT)) & WIDTH'(1));
    topDigit = (int'(stepIdx) == STEPS - 1);
    negDigit = strobe.lastStep && !topDigit && nextBit;
    digitVal = {2'b00, digit} - (negDigit ? {2'b01, {DIGIT{1'b0}}} : '0);
    digitExt = {{(WIDTH-DV_W){digitVal[DV_W-1]}}, digitVal};
    partial  = (mcand * digitExt) << (DIGIT * int'(stepIdx));
    accNext  = acc + partial;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      result <= '0;
    end else if (strobe.load) begin
      mcand  <= opA;
      mplier <= opB;
      acc    <= '0;
    end else if (strobe.step) begin
      acc <= accNext;
      if (strobe.lastStep) result <= accNext;
    end
  end

endmodule

// File: rtl/earlyMul.sv
module earlyMul
  import earlyMulPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DIGIT = 8,
  localparam int STEPS = WIDTH / DIGIT,
  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int CNT_W = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             condPass,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic [CNT_W-1:0] cycleCount
);

  mulStrobeT        strobe;
  logic [IDX_W-1:0] stepIdx;
  logic [CNT_W-1:0] tierNow;

  earlyMulTier #(.WIDTH(WIDTH), .DIGIT(DIGIT), .STEPS(STEPS), .CNT_W(CNT_W)) u_tier (
    .mplier (opB),
    .tier   (tierNow)
  );

  earlyMulCtrl #(.STEPS(STEPS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .condPass   (condPass),
    .tierIn     (tierNow),
    .strobe     (strobe),
    .stepIdx    (stepIdx),
    .busy       (busy),
    .done       (done),
    .cycleCount (cycleCount)
  );

  earlyMulPath #(.WIDTH(WIDTH), .DIGIT(DIGIT), .STEPS(STEPS), .IDX_W(IDX_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .opA     (opA),
    .opB     (opB),
    .result  (result)
  );

endmodule

// File: rtl/earlyMulChk.sv
module earlyMulChk #(
  parameter int WIDTH = 32,
  parameter int STEPS = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             condPass,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic [CNT_W-1:0] cycleCount
);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  // R6
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start && condPass));

  // R9
  start_in_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  // R7
  skip_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !condPass) |=>
      (done && (cycleCount == CNT_W'(0)) && $stable(result)));

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycleCount <= CNT_W'(STEPS)));

endmodule

bind earlyMul earlyMulChk #(.WIDTH(WIDTH), .STEPS(STEPS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .condPass   (condPass),
  .busy       (busy),
  .done       (done),
  .result     (result),
  .cycleCount (cycleCount)
);

// File: tb/earlyMul_tb.sv
`timescale 1ns/1ps
module earlyMul_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        condPass = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        busy;
  logic        done;
  logic [31:0] result;
  logic [2:0]  cycleCount;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  earlyMul u_dut (
    .clk(clk), .rstN(rstN), .start(start), .condPass(condPass),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .result(result), .cycleCount(cycleCount)
  );

  // {expected cycles, multiplicand, multiplier}
  localparam int NVEC = 14;
  localparam logic [66:0] VEC [NVEC] = '{
    {3'd1, 32'h12345678, 32'h00000000},
    {3'd1, 32'h12345678, 32'hFFFFFFFF},
    {3'd1, 32'h0000ABCD, 32'h000000FF},
    {3'd2, 32'h0000ABCD, 32'h00000100},
    {3'd1, 32'h87654321, 32'hFFFFFF00},
    {3'd2, 32'h87654321, 32'hFFFFFEFF},
    {3'd4, 32'h13579BDF, 32'h7FFFFFFF},
    {3'd3, 32'hFFFFFFFF, 32'h00123456},
    {3'd4, 32'h80000000, 32'h80000000},
    {3'd3, 32'hDEADBEEF, 32'hFF800000},
    {3'd2, 32'h00000003, 32'h00007FFF},
    {3'd2, 32'h7FFFFFFF, 32'hFFFF8000},
    {3'd4, 32'hCAFEF00D, 32'h01000000},
    {3'd1, 32'h00010001, 32'hFFFFFF80}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int tierOf(input logic [31:0] b);
    logic signed [31:0] s;
    s = $signed(b);
    if ((s >>> 8) == 0 || (s >>> 8) == -1) return 1;
    if ((s >>> 16) == 0 || (s >>> 16) == -1) return 2;
    if ((s >>> 24) == 0 || (s >>> 24) == -1) return 3;
    return 4;
  endfunction

  function automatic string tierReq(input int m);
    case (m)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  // issue one request; edges counts the sampling edge as 1
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic c,
                       output int edges, output logic busyAfter);
    @(negedge clk);
    opA = a; opB = b; condPass = c; start = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start = 1'b0;
    busyAfter = busy;
    while (!done && edges < 20) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
  endtask

  task automatic runOne(input logic [31:0] a, input logic [31:0] b, input int expM);
    int e;
    logic bz;
    logic [31:0] expP;
    expP = a * b;
    issue(a, b, 1'b1, e, bz);
    check(result == expP, "R1", "product", result, expP);
    check(int'(cycleCount) == expM, tierReq(expM), "cycleCount", cycleCount, expM);
    check(e == expM + 1, "R6", "latency edges", e, expM + 1);
    check(bz && !busy, "R8", "busy frame", {bz, busy}, 2'b10);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    int e;
    logic bz;
    logic [31:0] held;

    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && result == 0 && cycleCount == 0, "R10", "reset outputs",
          {busy, done, result, cycleCount}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R10", "idle after reset", {busy, done}, 0);

    for (int i = 0; i < NVEC; i++) begin
      check(tierOf(VEC[i][31:0]) == int'(VEC[i][66:64]), "R5", "vector tier table",
            tierOf(VEC[i][31:0]), VEC[i][66:64]);
      runOne(VEC[i][63:32], VEC[i][31:0], int'(VEC[i][66:64]));
    end

    // random operands, with the multiplier narrowed to each tier
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      ra = $urandom();
      rb = $urandom();
      case (i % 4)
        0: rb = 32'($signed(rb[8:0]));
        1: rb = 32'($signed(rb[16:0]));
        2: rb = 32'($signed(rb[24:0]));
        default: ;
      endcase
      runOne(ra, rb, tierOf(rb));
    end

    // R7: failed condition keeps the old result
    held = result;
    issue(32'h11111111, 32'h22222222, 1'b0, e, bz);
    check(e == 1, "R7", "skip latency", e, 1);
    check(cycleCount == 0, "R7", "skip cycleCount", cycleCount, 0);
    check(result == held, "R7", "skip result held", result, held);
    check(!bz, "R7", "skip not busy", bz, 0);
    @(negedge clk);
    check(!done, "R8", "done one cycle", done, 0);

    // R9: a second start during a 4-cycle multiply is ignored
    @(negedge clk);
    opA = 32'h01234567; opB = 32'h89ABCDEF; condPass = 1'b1; start = 1'b1;
    @(posedge clk);
    e = 1;
    @(negedge clk);
    opA = 32'h00000002; opB = 32'h00000003; start = 1'b1;
    @(posedge clk);
    e++;
    @(negedge clk);
    start = 1'b0;
    while (!done && e < 20) begin
      @(posedge clk);
      e++;
      @(negedge clk);
    end
    check(result == 32'(32'h01234567 * 32'h89ABCDEF), "R9", "original product kept",
          result, 32'(32'h01234567 * 32'h89ABCDEF));
    check(cycleCount == 3'd4 && e == 5, "R9", "original latency kept",
          {cycleCount, 8'(e)}, {3'd4, 8'd5});
    @(negedge clk);
    check(!done && !busy, "R9", "no extra run", {done, busy}, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule